// File: doc/BRIEF.md
# I2C Master Status Flag Register

This block is the read-only status byte of an I2C controller. Two of its bits are owned by the block itself. The master-activity flag records that this controller started the current transfer. The arbitration-lost flag records that another master won the bus. Each flag has its own set and clear rules.

The remaining six bits are registered copies of level signals that the surrounding controller supplies: extension code, address match, transmit/receive direction, acknowledge seen, start seen and stop seen. The block takes single-cycle event pulses from the bus engine, an enable level, a wakeup-enable level, and host-side read and single-bit access strobes. It returns the registered byte and a flag that marks when a host read is permitted.

When the wakeup enable is switched off, the whole byte stops following its inputs. It stays that way until the bus engine reports the next start or stop condition.

Top module: `i2c_mst_status_reg`

## Requirements
- R1: While reset is low, and on the first cycle after it, `status` reads 00h.
- R2: A pulse on `ev_start_gen` sets bit 7 (master flag) one clock later, unless a clearing event for that bit comes in the same cycle. If a clearing event does arrive in that cycle, the clear wins.
- R3: Bit 7 is 0 one clock after any of these: a stop-detected pulse, a release pulse or an arbitration-loss pulse.
- R4: A pulse on `ev_arb_lost` sets bit 6 (arbitration-lost flag) and clears bit 7 in the same clock update.
- R5: When `rd_stb` is high while `rd_valid` is high, bit 6 clears on the next clock. In the read cycle itself, `status` still shows the value from before the clear.
- R6: `bit_acc_stb` with `bit_acc_idx` naming any bit other than 6 clears bit 6 on the next clock. With index 6, bit 6 is left unchanged.
- R7: When an arbitration-loss pulse coincides with a read clear or a bit-access clear, bit 6 ends at 1.
- R8: When `module_en` falls from 1 to 0, bits 7 and 6 are both 0 on the next clock.
- R9: Bits 5..0 take the value of `lvl_stat[5:0]` one clock after it is applied, bit for bit. Bit 5 is extension code, bit 4 address match, bit 3 transmit, bit 2 ack detected, bit 1 start detected and bit 0 stop detected.
- R10: `rd_valid` equals `start_trig` OR `wait_prd`. A `rd_stb` that arrives while `rd_valid` is low has no effect on bit 6.
- R11: After `wake_en` falls from 1 to 0, all eight bits hold their value from the following clock onward. A pulse on `ev_start_det` or `ev_stop_det` ends the hold, and the update made in that cycle applies normally.
- R12: Events and level changes that arrive during the hold are dropped. They are not applied later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| module_en | input | 1 | Controller enable level |
| wake_en | input | 1 | Address-match wakeup enable level |
| ev_start_gen | input | 1 | Pulse: this controller issued a start |
| ev_start_det | input | 1 | Pulse: start condition seen on the bus |
| ev_stop_det | input | 1 | Pulse: stop condition seen on the bus |
| ev_arb_lost | input | 1 | Pulse: arbitration lost |
| ev_release | input | 1 | Pulse: exit-communication command |
| start_trig | input | 1 | Start-trigger control bit level |
| wait_prd | input | 1 | Controller is in a wait period |
| rd_stb | input | 1 | Host byte read of the register |
| bit_acc_stb | input | 1 | Host single-bit access |
| bit_acc_idx | input | 3 | Bit position of the single-bit access |
| lvl_stat | input | 6 | Level status inputs for bits 5..0 |
| status | output | 8 | Registered status byte |
| rd_valid | output | 1 | Host read permitted |

## Verification
The bench builds the block with its default 8-bit width, which gives a 3-bit access index and puts the arbitration flag at position 6. That width makes every index value reachable. Index 6 can therefore be checked against its neighbours, and both owned flags share the byte with all six captured levels. Coincident set and clear pulses, reads outside the permitted window, and a hold entered and left through stop detection are all driven at this width.

// File: rtl/i2cms_pkg.sv
package i2cms_pkg;
  typedef struct packed {
    logic start_gen;
    logic stop_det;
    logic arb_lost;
    logic release_cmd;
    logic en_fall;
  } flag_ev_t;
endpackage

// File: rtl/i2cms_fall_det.sv
module i2cms_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic fall
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign fall = lvl_q & ~lvl;
endmodule

// File: rtl/i2cms_freeze.sv
module i2cms_freeze (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_fall,
  input  logic start_det,
  input  logic stop_det,
  output logic frz_q,
  output logic upd_en
);
  logic bus_cond;
  assign bus_cond = start_det | stop_det;

  always_ff @(posedge clk) begin
    if (!rst_n)         frz_q <= 1'b0;
    else if (bus_cond)  frz_q <= 1'b0;
    else if (wake_fall) frz_q <= 1'b1;
  end

  assign upd_en = ~frz_q | bus_cond;
endmodule

// File: rtl/i2cms_flags.sv
module i2cms_flags
  import i2cms_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     upd_en,
  input  flag_ev_t ev,
  input  logic     rd_clr,
  input  logic     bit_clr,
  output logic     mst_q,
  output logic     ald_q
);
  logic mst_d, ald_d, mst_kill;

  assign mst_kill = ev.en_fall | ev.stop_det | ev.arb_lost | ev.release_cmd;

  always_comb begin
    mst_d = mst_q;
    if (mst_kill)          mst_d = 1'b0;
    else if (ev.start_gen) mst_d = 1'b1;

    ald_d = ald_q;
    if (ev.en_fall)            ald_d = 1'b0;
    else if (ev.arb_lost)      ald_d = 1'b1;
    else if (rd_clr | bit_clr) ald_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mst_q <= 1'b0;
      ald_q <= 1'b0;
    end else if (upd_en) begin
      mst_q <= mst_d;
      ald_q <= ald_d;
    end
  end
endmodule

// File: rtl/i2cms_lvl_cap.sv
module i2cms_lvl_cap #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dq
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)      dq[i] <= 1'b0;
      else if (upd_en) dq[i] <= din[i];
    end
  end
endmodule

// File: rtl/i2c_mst_status_reg.sv
module i2c_mst_status_reg
  import i2cms_pkg::*;
#(
  parameter  int STAT_W = 8,
  localparam int IDX_W  = $clog2(STAT_W),
  localparam int LVL_W  = STAT_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              module_en,
  input  logic              wake_en,
  input  logic              ev_start_gen,
  input  logic              ev_start_det,
  input  logic              ev_stop_det,
  input  logic              ev_arb_lost,
  input  logic              ev_release,
  input  logic              start_trig,
  input  logic              wait_prd,
  input  logic              rd_stb,
  input  logic              bit_acc_stb,
  input  logic [IDX_W-1:0]  bit_acc_idx,
  input  logic [LVL_W-1:0]  lvl_stat,
  output logic [STAT_W-1:0] status,
  output logic              rd_valid
);
  localparam int ALD_POS = STAT_W - 2;

  logic en_fall, wake_fall, frz_q, upd_en, mst_q, ald_q, rd_clr, bit_clr;
  logic [LVL_W-1:0] lvl_q;
  flag_ev_t ev;

  i2cms_fall_det u_en_edge (.clk(clk), .rst_n(rst_n), .lvl(module_en), .fall(en_fall));
  i2cms_fall_det u_wk_edge (.clk(clk), .rst_n(rst_n), .lvl(wake_en),   .fall(wake_fall));

  i2cms_freeze u_frz (
    .clk(clk), .rst_n(rst_n), .wake_fall(wake_fall),
    .start_det(ev_start_det), .stop_det(ev_stop_det),
    .frz_q(frz_q), .upd_en(upd_en)
  );

  assign rd_valid = start_trig | wait_prd;
  assign rd_clr   = rd_stb & rd_valid;
  assign bit_clr  = bit_acc_stb & (bit_acc_idx != IDX_W'(ALD_POS));

  assign ev.start_gen   = ev_start_gen;
  assign ev.stop_det    = ev_stop_det;
  assign ev.arb_lost    = ev_arb_lost;
  assign ev.release_cmd = ev_release;
  assign ev.en_fall     = en_fall;

  i2cms_flags u_flags (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .ev(ev),
    .rd_clr(rd_clr), .bit_clr(bit_clr), .mst_q(mst_q), .ald_q(ald_q)
  );

  i2cms_lvl_cap #(.W(LVL_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .din(lvl_stat), .dq(lvl_q)
  );

  assign status = {mst_q, ald_q, lvl_q};
endmodule

// File: rtl/i2cms_chk.sv
module i2cms_chk #(
  parameter int STAT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              module_en,
  input logic              ev_start_gen,
  input logic              ev_start_det,
  input logic              ev_stop_det,
  input logic              ev_arb_lost,
  input logic              ev_release,
  input logic              rd_stb,
  input logic              rd_valid,
  input logic              bit_acc_stb,
  input logic [STAT_W-1:0] status,
  input logic              upd_en,
  input logic              frz_q
);
  localparam int MP = STAT_W - 1;
  localparam int AP = STAT_W - 2;

  // R2
  mst_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start_gen && upd_en && module_en && !ev_stop_det && !ev_release && !ev_arb_lost
    |=> status[MP]);

  // R3
  mst_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop_det || ev_release) && upd_en |=> !status[MP]);

  // R4
  ald_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arb_lost && upd_en && module_en |=> status[AP] && !status[MP]);

  // R5
  ald_rdclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && rd_valid && upd_en && !ev_arb_lost |=> !status[AP]);

  // R10
  ald_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[AP] && rd_stb && !rd_valid && !bit_acc_stb && module_en |=> status[AP]);

  // R11
  frz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frz_q && !ev_start_det && !ev_stop_det |=> $stable(status));
endmodule

bind i2c_mst_status_reg i2cms_chk #(.STAT_W(STAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .module_en(module_en),
  .ev_start_gen(ev_start_gen), .ev_start_det(ev_start_det),
  .ev_stop_det(ev_stop_det), .ev_arb_lost(ev_arb_lost), .ev_release(ev_release),
  .rd_stb(rd_stb), .rd_valid(rd_valid), .bit_acc_stb(bit_acc_stb),
  .status(status), .upd_en(upd_en), .frz_q(frz_q)
);

// File: tb/i2c_mst_status_reg_bench.sv
`timescale 1ns/1ps
module i2c_mst_status_reg_bench;
  logic clk = 0, rst_n = 0;
  logic module_en = 0, wake_en = 0;
  logic ev_start_gen = 0, ev_start_det = 0, ev_stop_det = 0, ev_arb_lost = 0, ev_release = 0;
  logic start_trig = 0, wait_prd = 0, rd_stb = 0, bit_acc_stb = 0;
  logic [2:0] bit_acc_idx = 0;
  logic [5:0] lvl_stat = 0;
  logic [7:0] status;
  logic rd_valid;
  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  bit m_mst, m_ald, m_frz, m_en_q, m_wk_q;
  bit [5:0] m_low;

  always #2 clk = ~clk;

  i2c_mst_status_reg u_i2c_mst_status_reg (
    .clk(clk), .rst_n(rst_n), .module_en(module_en), .wake_en(wake_en),
    .ev_start_gen(ev_start_gen), .ev_start_det(ev_start_det), .ev_stop_det(ev_stop_det),
    .ev_arb_lost(ev_arb_lost), .ev_release(ev_release), .start_trig(start_trig),
    .wait_prd(wait_prd), .rd_stb(rd_stb), .bit_acc_stb(bit_acc_stb),
    .bit_acc_idx(bit_acc_idx), .lvl_stat(lvl_stat), .status(status), .rd_valid(rd_valid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mst = 0; m_ald = 0; m_frz = 0; m_en_q = 0; m_wk_q = 0; m_low = 0;
    end else begin
      bit enf, wkf, upd, rdc, bc;
      enf = m_en_q && !module_en;
      wkf = m_wk_q && !wake_en;
      m_en_q = module_en;
      m_wk_q = wake_en;
      upd = !m_frz || ev_start_det || ev_stop_det;
      if (ev_start_det || ev_stop_det) m_frz = 0;
      else if (wkf) m_frz = 1;
      if (upd) begin
        rdc = rd_stb && (start_trig || wait_prd);
        bc  = bit_acc_stb && (bit_acc_idx != 3'd6);
        if (enf) m_ald = 0;
        else if (ev_arb_lost) m_ald = 1;
        else if (rdc || bc) m_ald = 0;
        if (enf || ev_stop_det || ev_arb_lost || ev_release) m_mst = 0;
        else if (ev_start_gen) m_mst = 1;
        m_low = lvl_stat;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R2 model master", int'(status[7]), int'(m_mst));
    chk("R4 model arb-lost", int'(status[6]), int'(m_ald));
    chk("R9 model levels", int'(status[5:0]), int'(m_low));
    chk("R10 model rd_valid", int'(rd_valid), int'(start_trig | wait_prd));
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    module_en = 1;
    repeat (4) tick();
    chk("R1 reset value", int'(status), 0);
    rst_n = 1; tick();
    chk("R1 after reset", int'(status), 0);
    // R9 level capture
    lvl_stat = 6'b101101; tick();
    chk("R9 levels a", int'(status[5:0]), 6'h2d);
    lvl_stat = 6'b010010; tick();
    chk("R9 levels b", int'(status[5:0]), 6'h12);
    // R2 set
    ev_start_gen = 1; tick(); ev_start_gen = 0;
    chk("R2 master set", int'(status[7]), 1);
    // R3 clears
    ev_stop_det = 1; tick(); ev_stop_det = 0;
    chk("R3 stop clears", int'(status[7]), 0);
    ev_start_gen = 1; tick(); ev_start_gen = 0;
    ev_release = 1; tick(); ev_release = 0;
    chk("R3 release clears", int'(status[7]), 0);
    ev_start_gen = 1; ev_stop_det = 1; tick(); ev_start_gen = 0; ev_stop_det = 0;
    chk("R2 clear wins over set", int'(status[7]), 0);
    // R4 arbitration loss
    ev_start_gen = 1; tick(); ev_start_gen = 0;
    ev_arb_lost = 1; tick(); ev_arb_lost = 0;
    chk("R4 ald set", int'(status[6]), 1);
    chk("R3 R4 master cleared by loss", int'(status[7]), 0);
    // R10 read outside window ignored
    rd_stb = 1; #0;
    chk("R10 rd_valid low", int'(rd_valid), 0);
    tick(); rd_stb = 0; tick();
    chk("R10 read ignored", int'(status[6]), 1);
    // R5 read clear
    start_trig = 1; rd_stb = 1; #0;
    chk("R10 rd_valid high", int'(rd_valid), 1);
    chk("R5 pre-clear value", int'(status[6]), 1);
    tick(); rd_stb = 0; start_trig = 0;
    chk("R5 read clears", int'(status[6]), 0);
    // R6 bit access
    ev_arb_lost = 1; tick(); ev_arb_lost = 0;
    bit_acc_stb = 1; bit_acc_idx = 3'd6; tick();
    chk("R6 own index keeps", int'(status[6]), 1);
    bit_acc_idx = 3'd3; tick(); bit_acc_stb = 0;
    chk("R6 other index clears", int'(status[6]), 0);
    // R7 set beats clears
    ev_arb_lost = 1; wait_prd = 1; rd_stb = 1; bit_acc_stb = 1; bit_acc_idx = 3'd0;
    tick(); ev_arb_lost = 0; wait_prd = 0; rd_stb = 0; bit_acc_stb = 0;
    chk("R7 set wins", int'(status[6]), 1);
    // R8 enable fall
    ev_start_gen = 1; tick(); ev_start_gen = 0;
    module_en = 0; tick();
    chk("R8 master off", int'(status[7]), 0);
    chk("R8 ald off", int'(status[6]), 0);
    module_en = 1; tick();
    // R11 / R12 freeze
    ev_start_gen = 1; tick(); ev_start_gen = 0;
    wake_en = 1; tick();
    wake_en = 0; tick();
    lvl_stat = 6'b111000; ev_release = 1; tick(); ev_release = 0;
    ev_arb_lost = 1; tick(); ev_arb_lost = 0; tick();
    chk("R11 frozen master", int'(status[7]), 1);
    chk("R11 frozen levels", int'(status[5:0]), 6'h12);
    chk("R12 loss dropped during hold", int'(status[6]), 0);
    ev_stop_det = 1; tick(); ev_stop_det = 0;
    chk("R11 stop resumes levels", int'(status[5:0]), 6'h38);
    chk("R11 stop applied", int'(status[7]), 0);
    chk("R12 loss not replayed", int'(status[6]), 0);
    lvl_stat = 6'b000111; tick();
    chk("R11 updates again", int'(status[5:0]), 6'h07);
    repeat (3) tick();
    done = 1;
    summary();
    $finish;
  end
endmodule